// File: doc/BRIEF.md
# Gated Oversampling Serial Receiver

This block receives asynchronous serial frames of ten bits: a low start bit, eight data bits sent least significant first, and a high stop bit. A strobe that pulses once per sixteenth of a bit period drives its timing. The line passes through a two-flop synchronizer. A falling edge, seen while the receiver is idle, restarts the per-bit phase counter. Each bit is then decided by a two-of-three majority over the samples taken at phase states 7, 8 and 9. If the start bit is not voted low, the receiver drops it as a false start and waits for the next falling edge.

When the stop bit has been decided, the frame is kept or dropped. It is written to the data and stop registers, and the done flag is raised, only if the done flag is still clear and either the filter control is low or the stop bit was voted high. Otherwise nothing visible changes. Software-side logic clears the flag with a one-cycle strobe. The receiver returns to idle right after the stop-bit vote, so a following start edge is accepted without any extra idle time.

Top module: `serial_rx_gate`

## Requirements
- R1: After reset, `rx_byte` is 0x00, `rx_stop` is 0 and `rx_done` is 0.
- R2: While idle, a falling edge on the synchronized line starts a frame and zeroes the phase counter. Each bit lasts 16 `tick16` pulses.
- R3: Each bit value is the majority of the line samples taken at phase states 7, 8 and 9. A disturbance covering only one of those samples does not change the received bit.
- R4: A start bit whose vote is 1 is dropped. The receiver returns to idle without committing anything and accepts the next valid frame normally.
- R5: The first data bit after the start bit is bit 0 of `rx_byte` and the eighth is bit 7.
- R6: A committed frame loads `rx_byte` with the data, loads `rx_stop` with the voted stop bit and sets `rx_done` to 1.
- R7: A frame that completes while `rx_done` is 1 is dropped. `rx_byte`, `rx_stop` and `rx_done` keep their values.
- R8: With `filt_en` at 1, a frame whose stop bit votes 0 is dropped and one whose stop bit votes 1 is committed. With `filt_en` at 0, a stop-bit vote of 0 is committed and `rx_stop` reads 0.
- R9: A one-cycle `flag_clr` pulse clears `rx_done`. If `flag_clr` and a commit fall in the same cycle, the commit wins and `rx_done` stays 1.
- R10: The receiver accepts a new start edge arriving 12 phase ticks into the previous stop bit, and receives that frame correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| line_in | input | 1 | Serial line, idle high |
| filt_en | input | 1 | When 1, frames whose stop bit is 0 are dropped |
| flag_clr | input | 1 | One-cycle strobe that clears `rx_done` |
| rx_byte | output | 8 | Last committed data byte |
| rx_stop | output | 1 | Stop bit of the last committed frame |
| rx_done | output | 1 | Frame-received flag |

## Verification
Frames with alternating, paired and mixed bit patterns show that the bits are ordered LSB first and that the phase count is right. A frame with a short pulse against every data bit shows that the 2-of-3 vote, and not a single sample, decides the bit. A low pulse shorter than half a bit shows false-start rejection. Frames sent with the flag set, or with the filter on and the stop bit at 0, are compared against frames that are accepted, which shows the commit gate and its priority over the clear strobe. A pair of frames with a shortened stop bit shows that the receiver re-arms early.

// File: rtl/serial_rx_gate.sv
module serial_rx_gate #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              line_in,
  input  logic              filt_en,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_stop,
  output logic              rx_done
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DATA_W + 2);
  localparam int PH_A = OSR / 2 - 1;
  localparam logic [CW-1:0] PA   = CW'(PH_A);
  localparam logic [CW-1:0] PB   = CW'(PH_A + 1);
  localparam logic [CW-1:0] PC   = CW'(PH_A + 2);
  localparam logic [CW-1:0] PEND = CW'(OSR - 1);
  localparam logic [IW-1:0] LAST = IW'(DATA_W + 1);

  logic              s1, s2, prev;
  logic              busy;
  logic [CW-1:0]     ph;
  logic [IW-1:0]     idx;
  logic              smp_a, smp_b;
  logic [DATA_W-1:0] shreg;

  wire fall   = prev & ~s2;
  wire vote   = (smp_a & smp_b) | (smp_a & s2) | (smp_b & s2);
  wire decide = busy & tick16 & (ph == PC);
  wire last   = decide & (idx == LAST);
  wire commit = last & ~rx_done & (~filt_en | vote);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= line_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ph    <= '0;
      idx   <= '0;
      smp_a <= 1'b1;
      smp_b <= 1'b1;
      shreg <= '0;
    end else if (!busy) begin
      if (fall) begin
        busy <= 1'b1;
        ph   <= '0;
        idx  <= '0;
      end
    end else if (tick16) begin
      ph <= (ph == PEND) ? '0 : ph + 1'b1;
      if (ph == PA) smp_a <= s2;
      if (ph == PB) smp_b <= s2;
      if (ph == PC) begin
        if (idx == '0 && vote) begin
          busy <= 1'b0;
        end else if (idx == LAST) begin
          busy <= 1'b0;
        end else begin
          if (idx != '0) shreg <= {vote, shreg[DATA_W-1:1]};
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_stop <= 1'b0;
      rx_done <= 1'b0;
    end else if (commit) begin
      rx_byte <= shreg;
      rx_stop <= vote;
      rx_done <= 1'b1;
    end else if (flag_clr) begin
      rx_done <= 1'b0;
    end
  end

  p_hold_while_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> ($stable(rx_byte) && $stable(rx_stop)));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !flag_clr) |=> rx_done);

  p_commit_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && flag_clr) |=> rx_done);

  p_gate_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && filt_en && !vote) |=> $stable(rx_byte) && $stable(rx_done));

  p_idle_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fall) |=> !busy);

  p_load_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $rose(rx_done));
endmodule

// File: tb/serial_rx_gate_bench.sv
module serial_rx_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       line_in = 1'b1;
  logic       filt_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_stop;
  logic       rx_done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [1:0] tdiv = '0;

  localparam int BITC = 64;

  serial_rx_gate u_serial_rx_gate (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_in(line_in),
    .filt_en(filt_en), .flag_clr(flag_clr),
    .rx_byte(rx_byte), .rx_stop(rx_stop), .rx_done(rx_done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
    cyc    <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    line_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stp, input int stoplen, input bit glitch);
    hold(1'b0, BITC);
    for (int i = 0; i < 8; i++) begin
      if (glitch) begin
        hold(d[i], 30);
        hold(~d[i], 4);
        hold(d[i], BITC - 34);
      end else begin
        hold(d[i], BITC);
      end
    end
    hold(stp, stoplen);
    line_in = 1'b1;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(rx_byte == 8'h00, "R1 byte", rx_byte, 0);
    chk(rx_stop == 1'b0, "R1 stop", rx_stop, 0);
    chk(rx_done == 1'b0, "R1 done", rx_done, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 1'b1, BITC, 0); hold(1'b1, 16);
    chk(rx_byte == 8'hA5, "R5 R2 byte A5", rx_byte, 8'hA5);
    chk(rx_stop == 1'b1, "R6 stop", rx_stop, 1);
    chk(rx_done == 1'b1, "R6 done", rx_done, 1);
    clear_flag();
    chk(rx_done == 1'b0, "R9 clear", rx_done, 0);
    send(8'h01, 1'b1, BITC, 0); hold(1'b1, 16);
    chk(rx_byte == 8'h01, "R5 lsb first", rx_byte, 8'h01);
    clear_flag();
  endtask

  task automatic t_flag_block();
    send(8'h11, 1'b1, BITC, 0); hold(1'b1, 16);
    send(8'h3C, 1'b1, BITC, 0); hold(1'b1, 16);
    chk(rx_byte == 8'h11, "R7 byte kept", rx_byte, 8'h11);
    chk(rx_done == 1'b1, "R7 done kept", rx_done, 1);
    clear_flag();
  endtask

  task automatic t_filter();
    filt_en = 1'b1;
    send(8'h77, 1'b0, BITC, 0); hold(1'b1, 16);
    chk(rx_done == 1'b0, "R8 filt drop done", rx_done, 0);
    chk(rx_byte == 8'h11, "R8 filt drop byte", rx_byte, 8'h11);
    send(8'h42, 1'b1, BITC, 0); hold(1'b1, 16);
    chk(rx_byte == 8'h42 && rx_done, "R8 filt accept", rx_byte, 8'h42);
    clear_flag();
    filt_en = 1'b0;
    send(8'h5A, 1'b0, BITC, 0); hold(1'b1, 16);
    chk(rx_byte == 8'h5A && rx_done, "R8 nofilt accept", rx_byte, 8'h5A);
    chk(rx_stop == 1'b0, "R8 stop zero", rx_stop, 0);
    clear_flag();
  endtask

  task automatic t_glitch();
    send(8'hC3, 1'b1, BITC, 1); hold(1'b1, 16);
    chk(rx_byte == 8'hC3 && rx_done, "R3 vote", rx_byte, 8'hC3);
    clear_flag();
  endtask

  task automatic t_false_start();
    hold(1'b0, 20);
    hold(1'b1, 3 * BITC);
    chk(rx_done == 1'b0, "R4 no commit", rx_done, 0);
    chk(rx_byte == 8'hC3, "R4 byte kept", rx_byte, 8'hC3);
    send(8'h96, 1'b1, BITC, 0); hold(1'b1, 16);
    chk(rx_byte == 8'h96 && rx_done, "R4 recover", rx_byte, 8'h96);
    clear_flag();
  endtask

  task automatic t_priority();
    bit seen = 0;
    fork
      send(8'hE1, 1'b1, BITC, 0);
      begin
        flag_clr = 1'b1;
        for (int i = 0; i < 800; i++) begin
          @(negedge clk);
          if (rx_done) begin seen = 1; break; end
        end
        flag_clr = 1'b0;
      end
    join
    hold(1'b1, 16);
    chk(seen && rx_done, "R9 commit wins", rx_done, 1);
    chk(rx_byte == 8'hE1, "R9 byte", rx_byte, 8'hE1);
    clear_flag();
  endtask

  task automatic t_back2back();
    logic [7:0] first = '0;
    logic [7:0] second = '0;
    fork
      begin
        send(8'h12, 1'b1, 48, 0);
        send(8'h34, 1'b1, BITC, 0);
        hold(1'b1, 16);
      end
      begin
        while (!rx_done) @(negedge clk);
        first = rx_byte;
        clear_flag();
        while (!rx_done) @(negedge clk);
        second = rx_byte;
      end
    join
    chk(first == 8'h12, "R10 first", first, 8'h12);
    chk(second == 8'h34, "R10 second", second, 8'h34);
    clear_flag();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_basic();
    t_flag_block();
    t_filter();
    t_glitch();
    t_false_start();
    t_priority();
    t_back2back();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule